// File: doc/BRIEF.md
# PCI Pass-Through Window Decoder

This block watches the local bus for accesses that land inside a fixed address window reserved for PCI pass-through. A claimed access becomes one request to a PCI initiator stub. The local address goes across unchanged as the PCI address, and the read or write direction goes across as it is. The bus command class comes from the top two bits of the initiator control register. Bit 0 of that register picks between DMA operation and direct addressing. The decoder claims nothing while DMA operation is selected.

The local master holds its request, with address, size and direction, until the decoder answers with a one-cycle ready or error pulse. For a forwarded access the decoder keeps the master waiting until the initiator stub reports completion. The decoder rejects some claimed accesses at once with an error and never forwards them: a reserved command class, a misaligned halfword or word, or an undefined size code. The decoder leaves accesses outside the window alone, so another target on the local bus can answer them.

Top module: `pci_window_decoder`

## Requirements
- R1: An access is claimed only when 0xA0000000 <= locAddr < 0xF0000000. An access outside that range produces no pciReq, no locReady and no locErr.
- R2: While ctrlReg bit 0 is 1 (DMA operation) no access is claimed, even one inside the window. Direct addressing is active only while that bit is 0.
- R3: A forwarded request carries pciAddr equal to locAddr and pciWrite equal to locWrite.
- R4: ctrlReg[31:30] selects the command class. With write = 0 / write = 1, the pciCmd codes are: 00 gives I/O (0010 / 0011), 01 gives memory (0110 / 0111), 10 gives configuration (1010 / 1011).
- R5: If ctrlReg[31:30] = 11 (reserved), a claimed access produces locErr one cycle after it is sampled, and no pciReq.
- R6: pciByteEn bit i enables byte lane i. locSize 0 (byte) enables lane locAddr[1:0]. locSize 1 (halfword) enables lanes 1:0 or 3:2, chosen by locAddr[1]. locSize 2 (word) enables all four lanes.
- R7: A claimed halfword with locAddr[0] = 1, a word with locAddr[1:0] != 0, or locSize 3 gets the same immediate locErr as R5, and no pciReq.
- R8: pciReq is high for exactly one cycle. That cycle follows the clock edge that samples the claimed access.
- R9: locReady pulses for one cycle, in the cycle after the edge that samples pciDone. Before that the master sees neither locReady nor locErr.
- R10: A pciErr from the stub is answered with a one-cycle locErr in the cycle after the edge that samples it.
- R11: During and right after reset, pciReq, locReady and locErr are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, synchronous |
| ctrlReg | input | 32 | Initiator control register: [31:30] command class, [0] DMA mode |
| locReq | input | 1 | Local access request, held until a response arrives |
| locWrite | input | 1 | Local access is a write |
| locAddr | input | 32 | Local byte address |
| locSize | input | 2 | 0 byte, 1 halfword, 2 word, 3 undefined |
| locReady | output | 1 | One-cycle successful completion |
| locErr | output | 1 | One-cycle error response |
| pciReq | output | 1 | One-cycle request strobe to the initiator stub |
| pciAddr | output | 32 | PCI address |
| pciCmd | output | 4 | PCI bus command code |
| pciByteEn | output | 4 | Active-high byte lane enables |
| pciWrite | output | 1 | Request direction, 1 = write |
| pciDone | input | 1 | Stub reports completion |
| pciErr | input | 1 | Stub reports failure |

## Verification
The request strobe is due exactly one cycle after the master raises a claimed access. A rejection answer is also due after one cycle. A forwarded access completes L+2 cycles after the request, where L is the number of cycles the stub model waits after it sees the strobe before it answers. The driver computes that due cycle and counts falling edges from the moment it raises locReq, so the check happens at that count. A response that comes early or late, or not at all, is counted as a failure. The monitor compares each request strobe field by field against the item queued for it in the same falling-edge sample. For accesses that must be ignored, the driver waits six cycles with the request held and confirms that neither a response nor a strobe appears.

// File: rtl/pwd_pkg.sv
package pwd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_OK,
    ST_FAIL
  } pwdState_t;

  typedef struct packed {
    logic capture;
    logic hold;
  } pwdStrobes_t;

  localparam logic [1:0] CLS_IO   = 2'b00;
  localparam logic [1:0] CLS_MEM  = 2'b01;
  localparam logic [1:0] CLS_CFG  = 2'b10;
  localparam logic [1:0] CLS_RSVD = 2'b11;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

endpackage

// File: rtl/pwd_datapath.sv
module pwd_datapath
  import pwd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CTRL_W = 32,
  parameter int LANES = 4,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'hA000_0000,
  parameter logic [ADDR_W-1:0] WIN_LIMIT = 32'hF000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwdStrobes_t       strobes,
  input  logic [CTRL_W-1:0] ctrlReg,
  input  logic              locWrite,
  input  logic [ADDR_W-1:0] locAddr,
  input  logic [1:0]        locSize,
  output logic              claim,
  output logic              reject,
  output logic [ADDR_W-1:0] pciAddr,
  output logic [3:0]        pciCmd,
  output logic [LANES-1:0]  pciByteEn,
  output logic              pciWrite
);

  localparam int OFS_W = $clog2(LANES);
  localparam int EXT_W = OFS_W + 2;

  logic [OFS_W-1:0] offset;
  logic [EXT_W-1:0] offExt;
  logic [EXT_W-1:0] sizeBytes;
  logic [EXT_W-1:0] endExt;
  logic [1:0]       cmdCls;
  logic             dmaMode;
  logic             winHit;
  logic             sizeOk;
  logic             aligned;
  logic [LANES-1:0] laneEn;
  logic [3:0]       cmdCode;

  assign offset  = locAddr[OFS_W-1:0];
  assign offExt  = EXT_W'(offset);
  assign cmdCls  = ctrlReg[CTRL_W-1 -: 2];
  assign dmaMode = ctrlReg[0];
  assign winHit  = (locAddr >= WIN_BASE) && (locAddr < WIN_LIMIT);
  assign claim   = winHit && !dmaMode;

  always_comb begin
    sizeOk = 1'b1;
    case (locSize)
      SZ_BYTE: sizeBytes = EXT_W'(1);
      SZ_HALF: sizeBytes = EXT_W'(2);
      SZ_WORD: sizeBytes = EXT_W'(LANES);
      default: begin
        sizeBytes = EXT_W'(1);
        sizeOk    = 1'b0;
      end
    endcase
  end

  assign endExt  = offExt + sizeBytes;
  assign aligned = ((offExt & (sizeBytes - EXT_W'(1))) == '0);
  assign reject  = (cmdCls == CLS_RSVD) || !sizeOk || !aligned;

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    assign laneEn[lane] = (EXT_W'(lane) >= offExt) && (EXT_W'(lane) < endExt);
  end

  always_comb begin
    case (cmdCls)
      CLS_IO:  cmdCode = {3'b001, locWrite};
      CLS_MEM: cmdCode = {3'b011, locWrite};
      CLS_CFG: cmdCode = {3'b101, locWrite};
      default: cmdCode = 4'b0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pciAddr   <= '0;
      pciCmd    <= '0;
      pciByteEn <= '0;
      pciWrite  <= 1'b0;
    end else if (strobes.capture) begin
      pciAddr   <= locAddr;
      pciCmd    <= cmdCode;
      pciByteEn <= laneEn;
      pciWrite  <= locWrite;
    end
  end

  // R3: captured request fields stay put while the control holds them
  a_r3_fields_held: assert property (@(posedge clk) disable iff (!rstN)
    strobes.hold |=> $stable(pciAddr) && $stable(pciWrite));

  // R6: a captured enable pattern covers one, two or all lanes
  a_r6_lane_count: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> ($countones(pciByteEn) == 1) || ($countones(pciByteEn) == 2)
                        || ($countones(pciByteEn) == LANES));

endmodule

// File: rtl/pwd_control.sv
module pwd_control
  import pwd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        locReq,
  input  logic        claim,
  input  logic        reject,
  input  logic        pciDone,
  input  logic        pciErr,
  output pwdStrobes_t strobes,
  output logic        pciReq,
  output logic        locReady,
  output logic        locErr
);

  pwdState_t state;
  pwdState_t stateNext;

  always_comb begin
    stateNext       = state;
    strobes.capture = 1'b0;
    case (state)
      ST_IDLE: begin
        if (locReq && claim) begin
          if (reject) begin
            stateNext = ST_FAIL;
          end else begin
            stateNext       = ST_ISSUE;
            strobes.capture = 1'b1;
          end
        end
      end
      ST_ISSUE: stateNext = ST_WAIT;
      ST_WAIT: begin
        if (pciErr) stateNext = ST_FAIL;
        else if (pciDone) stateNext = ST_OK;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign strobes.hold = (state == ST_ISSUE) || (state == ST_WAIT);

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else state <= stateNext;
  end

  assign pciReq   = (state == ST_ISSUE);
  assign locReady = (state == ST_OK);
  assign locErr   = (state == ST_FAIL);

  // R8: the request strobe lasts one cycle
  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    pciReq |=> !pciReq);

  // R9: a ready pulse is always preceded by a sampled completion
  a_r9_ready_after_done: assert property (@(posedge clk) disable iff (!rstN)
    locReady |-> $past(pciDone));

  // R9: ready and error never coincide
  a_r9_exclusive_resp: assert property (@(posedge clk) disable iff (!rstN)
    !(locReady && locErr));

  // R5: a rejected access errors at once and is not forwarded
  a_r5_reject_no_req: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && locReq && claim && reject) |=> locErr && !pciReq);

endmodule

// File: rtl/pci_window_decoder.sv
module pci_window_decoder
  import pwd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CTRL_W = 32,
  parameter int LANES = 4,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'hA000_0000,
  parameter logic [ADDR_W-1:0] WIN_LIMIT = 32'hF000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CTRL_W-1:0] ctrlReg,
  input  logic              locReq,
  input  logic              locWrite,
  input  logic [ADDR_W-1:0] locAddr,
  input  logic [1:0]        locSize,
  output logic              locReady,
  output logic              locErr,
  output logic              pciReq,
  output logic [ADDR_W-1:0] pciAddr,
  output logic [3:0]        pciCmd,
  output logic [LANES-1:0]  pciByteEn,
  output logic              pciWrite,
  input  logic              pciDone,
  input  logic              pciErr
);

  pwdStrobes_t strobes;
  logic        claim;
  logic        reject;

  pwd_datapath #(
    .ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .LANES(LANES),
    .WIN_BASE(WIN_BASE), .WIN_LIMIT(WIN_LIMIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .ctrlReg(ctrlReg),
    .locWrite(locWrite), .locAddr(locAddr), .locSize(locSize),
    .claim(claim), .reject(reject), .pciAddr(pciAddr), .pciCmd(pciCmd),
    .pciByteEn(pciByteEn), .pciWrite(pciWrite)
  );

  pwd_control u_ctl (
    .clk(clk), .rstN(rstN), .locReq(locReq), .claim(claim), .reject(reject),
    .pciDone(pciDone), .pciErr(pciErr), .strobes(strobes), .pciReq(pciReq),
    .locReady(locReady), .locErr(locErr)
  );

  // R1: every forwarded address lies inside the window
  a_r1_req_in_window: assert property (@(posedge clk) disable iff (!rstN)
    pciReq |-> (pciAddr >= WIN_BASE) && (pciAddr < WIN_LIMIT));

  // R4: the low command bit agrees with the direction
  a_r4_dir_in_cmd: assert property (@(posedge clk) disable iff (!rstN)
    pciReq |-> pciCmd[0] == pciWrite);

endmodule

// File: tb/sim_pci_window_decoder.sv
`timescale 1ns/1ps
module sim_pci_window_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] ctrlReg = '0;
  logic        locReq = 1'b0;
  logic        locWrite = 1'b0;
  logic [31:0] locAddr = '0;
  logic [1:0]  locSize = '0;
  logic        locReady, locErr, pciReq, pciWrite;
  logic [31:0] pciAddr;
  logic [3:0]  pciCmd, pciByteEn;
  logic        pciDone = 1'b0;
  logic        pciErr = 1'b0;

  int nChecks = 0;
  int nFails = 0;
  int stubLat = 1;
  bit stubFail = 1'b0;
  bit finished = 1'b0;

  typedef struct packed {
    logic [31:0] addr;
    logic [3:0]  cmd;
    logic [3:0]  be;
    logic        wr;
  } expItem_t;
  expItem_t expQ[$];

  always #10 clk = ~clk;

  pci_window_decoder u0 (
    .clk(clk), .rstN(rstN), .ctrlReg(ctrlReg), .locReq(locReq),
    .locWrite(locWrite), .locAddr(locAddr), .locSize(locSize),
    .locReady(locReady), .locErr(locErr), .pciReq(pciReq), .pciAddr(pciAddr),
    .pciCmd(pciCmd), .pciByteEn(pciByteEn), .pciWrite(pciWrite),
    .pciDone(pciDone), .pciErr(pciErr)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] expCmd(input logic [1:0] cls, input logic wr);
    case (cls)
      2'b00: return {3'b001, wr};
      2'b01: return {3'b011, wr};
      default: return {3'b101, wr};
    endcase
  endfunction

  function automatic logic [3:0] expBe(input logic [1:0] sz, input logic [1:0] ofs);
    case (sz)
      2'd0: return 4'b0001 << ofs;
      2'd1: return 4'b0011 << ofs;
      default: return 4'b1111;
    endcase
  endfunction

  // stub: answer a strobe stubLat cycles after it is seen
  initial begin
    forever begin
      @(negedge clk);
      if (pciReq) begin
        repeat (stubLat) @(negedge clk);
        if (stubFail) pciErr = 1'b1;
        else pciDone = 1'b1;
        @(negedge clk);
        pciDone = 1'b0;
        pciErr = 1'b0;
      end
    end
  end

  // monitor: every strobe must match the front of the queue
  initial begin
    forever begin
      @(negedge clk);
      if (pciReq) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R1/R2/R5/R7 unexpected pciReq", 64'(pciAddr), 64'h0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(pciAddr == e.addr, "R3 address", 64'(pciAddr), 64'(e.addr));
          check(pciWrite == e.wr, "R3 direction", 64'(pciWrite), 64'(e.wr));
          check(pciCmd == e.cmd, "R4 command", 64'(pciCmd), 64'(e.cmd));
          check(pciByteEn == e.be, "R6 byte enables", 64'(pciByteEn), 64'(e.be));
        end
      end
    end
  end

  // kind: 0 ignored, 1 rejected, 2 forwarded ok, 3 forwarded stub error
  task automatic access(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                        input logic [31:0] ctl, input int kind, input int lat,
                        input string req);
    int dueK, maxK, respK;
    bit gotErr;
    stubLat = lat;
    stubFail = (kind == 3);
    if (kind >= 2) expQ.push_back('{a, expCmd(ctl[31:30], wr), expBe(sz, a[1:0]), wr});
    dueK = (kind == 0) ? 0 : (kind == 1) ? 1 : 2 + lat;
    maxK = (kind == 0) ? 6 : dueK + 2;
    @(negedge clk);
    ctrlReg = ctl; locAddr = a; locSize = sz; locWrite = wr; locReq = 1'b1;
    respK = 0;
    gotErr = 1'b0;
    for (int k = 1; k <= maxK; k++) begin
      @(negedge clk);
      if (locReady || locErr) begin
        respK = k;
        gotErr = locErr;
        break;
      end
    end
    check(respK == dueK, {req, " response cycle"}, 64'(respK), 64'(dueK));
    if (kind != 0)
      check(gotErr == (kind != 2), {req, " response kind"}, 64'(gotErr), 64'(kind != 2));
    locReq = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: outputs quiet under reset
    check(!pciReq && !locReady && !locErr, "R11 reset outputs",
          64'({pciReq, locReady, locErr}), 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(!pciReq && !locReady && !locErr, "R11 after reset",
          64'({pciReq, locReady, locErr}), 64'h0);

    access(32'hA000_0000, 2'd0, 1'b0, 32'h0000_0000, 2, 1, "R9 io byte read");
    access(32'hA000_0102, 2'd1, 1'b1, 32'h0000_0000, 2, 3, "R9 io half write");
    access(32'hC000_0010, 2'd2, 1'b0, 32'h4000_0000, 2, 2, "R4 mem word read");
    access(32'hEFFF_FFFF, 2'd0, 1'b1, 32'h8000_0000, 2, 1, "R1 cfg byte top");
    access(32'hB000_0000, 2'd1, 1'b1, 32'h4000_0000, 2, 1, "R6 mem half low");
    access(32'hA000_0006, 2'd0, 1'b0, 32'h0000_0000, 2, 4, "R6 byte lane 2");
    access(32'h9FFF_FFFC, 2'd2, 1'b0, 32'h0000_0000, 0, 1, "R1 below window");
    access(32'hF000_0000, 2'd2, 1'b0, 32'h0000_0000, 0, 1, "R1 at limit");
    access(32'hA000_0000, 2'd2, 1'b0, 32'h0000_0001, 0, 1, "R2 dma mode");
    access(32'hA000_0000, 2'd2, 1'b0, 32'hC000_0000, 1, 1, "R5 reserved class");
    access(32'hA000_0001, 2'd1, 1'b0, 32'h0000_0000, 1, 1, "R7 odd half");
    access(32'hA000_0002, 2'd2, 1'b1, 32'h0000_0000, 1, 1, "R7 unaligned word");
    access(32'hA000_0000, 2'd3, 1'b0, 32'h0000_0000, 1, 1, "R7 undefined size");
    access(32'hA000_0040, 2'd2, 1'b1, 32'h0000_0000, 3, 2, "R10 stub error");
    access(32'hA000_0044, 2'd2, 1'b0, 32'h0000_0000, 2, 1, "R8 after error");

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R8 missing pciReq", 64'(expQ.size()), 64'h0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule